// File: doc/BRIEF.md
# Timing pulse output generator

This block drives a set of timing output pins (four by default) from a nanosecond time base. Each cycle the time-of-day counter reports how many nanoseconds it advanced (`tod_step`), and it raises `tod_sec_wrap` in the cycle where the seconds field rolls over. Software configures one pin per write. The write selects either the stopped action or the running action, a sync flag, and two 32-bit nanosecond values. The pin takes the new setting at the clock edge that samples the write. Before it does, the values are checked against a range. A rejected write leaves the pin untouched and pulses `cfg_reject`.

In free-running mode the pin alternates between a low phase and a high phase, and each phase lasts its programmed number of time-base nanoseconds. Any nanoseconds left over at a phase change carry into the next phase, so the waveform does not drift. In synchronized mode the low value is a phase offset measured from each second rollover, and the high value is the pulse width. A zero high value selects a default: the same length as the low phase in free-running mode, or 1000 ns in synchronized mode.

Each pin runs its own state machine:
- `ST_IDLE` (output low).
- `ST_FREE_LOW` and `ST_FREE_HIGH`.
- `ST_SYNC_ARM`: armed, waiting for the first rollover.
- `ST_SYNC_WAIT`: counting the offset.
- `ST_SYNC_HIGH`: pulse.
- `ST_SYNC_DONE`: pulse finished.

Transitions:
- A stop write goes to `ST_IDLE`. A free-running write goes to `ST_FREE_LOW`. A sync write goes to `ST_SYNC_ARM`.
- `ST_FREE_LOW` goes to `ST_FREE_HIGH` once the low time has elapsed. `ST_FREE_HIGH` returns to `ST_FREE_LOW` once the high time has elapsed.
- A rollover moves any sync state to `ST_SYNC_WAIT`, or to `ST_SYNC_HIGH` when the offset is zero.
- `ST_SYNC_WAIT` goes to `ST_SYNC_HIGH` when the offset is reached.
- `ST_SYNC_HIGH` goes to `ST_SYNC_DONE` when the width is reached.

Top module: `ppg_top`

## Requirements
- R1: While reset is active and after it is released, every bit of `pin_out` and `cfg_reject` is 0 until a write is accepted.
- R2: An accepted write with `cfg_clock`=0 (stop) forces that pin's output low from the cycle after the write edge. The pin stays low, and its phase count restarts from zero on the next running write.
- R3: An accepted write with `cfg_clock`=1 and `cfg_sync`=0 starts free-running mode. Let k count cycles after the write edge (k=0 is the first), and let t be the sum of `tod_step` over edges 1..k. The output is high exactly when (t mod (L+H)) >= L, where L is the low value and H the high value.
- R4: In free-running mode, L and the effective H must each lie between 7 and 0x3FFFFFFF inclusive. Otherwise the write is rejected: `cfg_reject` is 1 for the one cycle after the write edge, and the pin keeps its previous waveform.
- R5: In free-running mode, a high value of 0 makes H equal to L (50 % duty).
- R6: An accepted write with `cfg_clock`=1 and `cfg_sync`=1 holds the pin low until the next `tod_sec_wrap` edge. Let t be the nanoseconds summed since the latest rollover edge (t=0 in the cycle after it). The output is then high exactly when P <= t < P+W, where the offset P is the low 30 bits of `cfg_low` and W is the width.
- R7: In synchronized mode the width W must lie between 7 and 0x3FFFFFFF, or the write is rejected as in R4. The offset P is not range-checked.
- R8: In synchronized mode, a high value of 0 selects W = 1000 ns.
- R9: A rollover that arrives during the pulse restarts the count from zero. With P=0 the output stays high across the rollover without dropping.
- R10: When an accepted write and `tod_sec_wrap` fall on the same edge, the written pin takes the write and ignores that rollover. Other pins still act on the rollover.
- R11: A write to one pin, accepted or rejected, does not change the waveform of any other pin.
- R12: A cycle with `tod_step`=0 and no rollover or write leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tod_step | input | STEP_W (3) | Nanoseconds the time base advanced this cycle (0..7) |
| tod_sec_wrap | input | 1 | Second rollover strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pin | input | PIN_W (2) | Pin index for the write |
| cfg_clock | input | 1 | 1 = running action, 0 = stop |
| cfg_sync | input | 1 | 1 = synchronized to second rollovers |
| cfg_high | input | IN_W (32) | High time / pulse width in ns (0 = default) |
| cfg_low | input | IN_W (32) | Low time, or phase offset in sync mode, in ns |
| cfg_reject | output | 1 | One-cycle pulse after a rejected write |
| pin_out | output | NUM_PINS (4) | Pin outputs |

## Verification
The interesting collision is a configuration write landing on the same edge as a second rollover. A sync pin that was written then must ignore the rollover and stay armed, while a second sync pin running at the same time restarts its pulse. The bench issues exactly such a write, with the strobe raised on the same edge, and its time-based model predicts both pins over the following cycles. A second collision case is a rollover arriving during a pulse that has zero offset. Here the model expects an unbroken high level, and every cycle is compared.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREE_LOW,
        ST_FREE_HIGH,
        ST_SYNC_ARM,
        ST_SYNC_WAIT,
        ST_SYNC_HIGH,
        ST_SYNC_DONE
    } ppg_state_e;

    function automatic logic is_sync_state(input ppg_state_e s);
        return (s == ST_SYNC_ARM) || (s == ST_SYNC_WAIT) ||
               (s == ST_SYNC_HIGH) || (s == ST_SYNC_DONE);
    endfunction

endpackage

// File: rtl/ppg_cfg_check.sv
module ppg_cfg_check #(
    parameter int IN_W         = 32,
    parameter int PER_W        = 30,
    parameter int MIN_NS       = 7,
    parameter int DEF_WIDTH_NS = 1000
) (
    input  logic             run,
    input  logic             sync,
    input  logic [IN_W-1:0]  high_in,
    input  logic [IN_W-1:0]  low_in,
    output logic             ok,
    output logic [PER_W-1:0] high_eff,
    output logic [PER_W-1:0] low_eff
);
    localparam logic [IN_W-1:0] MAX_V = IN_W'((64'd1 << PER_W) - 64'd1);
    localparam logic [IN_W-1:0] MIN_V = IN_W'(MIN_NS);
    localparam logic [IN_W-1:0] DEF_V = IN_W'(DEF_WIDTH_NS);

    logic [IN_W-1:0] hi_w;
    logic            hi_ok;
    logic            lo_ok;

    always_comb begin
        if (high_in == '0) begin
            hi_w = sync ? DEF_V : low_in;
        end else begin
            hi_w = high_in;
        end
        hi_ok = (hi_w >= MIN_V) && (hi_w <= MAX_V);
        lo_ok = (low_in >= MIN_V) && (low_in <= MAX_V);
        if (!run) begin
            ok = 1'b1;
        end else if (sync) begin
            ok = hi_ok;
        end else begin
            ok = hi_ok && lo_ok;
        end
        high_eff = hi_w[PER_W-1:0];
        low_eff  = low_in[PER_W-1:0];
    end
endmodule

// File: rtl/ppg_pin_fsm.sv
module ppg_pin_fsm
    import ppg_pkg::*;
#(
    parameter int PER_W  = 30,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_run,
    input  logic              load_sync,
    input  logic [PER_W-1:0]  load_high,
    input  logic [PER_W-1:0]  load_low,
    input  logic [STEP_W-1:0] step,
    input  logic              sec_wrap,
    output logic              out
);
    localparam int SUM_W = PER_W + 1;

    ppg_state_e       state, state_nxt;
    logic [PER_W-1:0] cnt, cnt_nxt;
    logic [PER_W-1:0] hi_r, lo_r;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] sum_lo;
    logic [SUM_W-1:0] sum_hi;

    assign sum    = {1'b0, cnt} + SUM_W'(step);
    assign sum_lo = sum - {1'b0, lo_r};
    assign sum_hi = sum - {1'b0, hi_r};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            hi_r  <= '0;
            lo_r  <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (load) begin
                hi_r <= load_high;
                lo_r <= load_low;
            end
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (load) begin
            cnt_nxt = '0;
            if (!load_run) begin
                state_nxt = ST_IDLE;
            end else if (load_sync) begin
                state_nxt = ST_SYNC_ARM;
            end else begin
                state_nxt = ST_FREE_LOW;
            end
        end else if (sec_wrap && is_sync_state(state)) begin
            cnt_nxt   = '0;
            state_nxt = (lo_r == '0) ? ST_SYNC_HIGH : ST_SYNC_WAIT;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt_nxt = '0;
                end
                ST_FREE_LOW: begin
                    if (sum >= {1'b0, lo_r}) begin
                        state_nxt = ST_FREE_HIGH;
                        cnt_nxt   = sum_lo[PER_W-1:0];
                    end else begin
                        cnt_nxt = sum[PER_W-1:0];
                    end
                end
                ST_FREE_HIGH: begin
                    if (sum >= {1'b0, hi_r}) begin
                        state_nxt = ST_FREE_LOW;
                        cnt_nxt   = sum_hi[PER_W-1:0];
                    end else begin
                        cnt_nxt = sum[PER_W-1:0];
                    end
                end
                ST_SYNC_ARM: begin
                    cnt_nxt = '0;
                end
                ST_SYNC_WAIT: begin
                    if (sum >= {1'b0, lo_r}) begin
                        state_nxt = ST_SYNC_HIGH;
                        cnt_nxt   = sum_lo[PER_W-1:0];
                    end else begin
                        cnt_nxt = sum[PER_W-1:0];
                    end
                end
                ST_SYNC_HIGH: begin
                    if (sum >= {1'b0, hi_r}) begin
                        state_nxt = ST_SYNC_DONE;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = sum[PER_W-1:0];
                    end
                end
                ST_SYNC_DONE: begin
                    cnt_nxt = '0;
                end
                default: begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        out = (state == ST_FREE_HIGH) || (state == ST_SYNC_HIGH);
    end
endmodule

// File: rtl/ppg_top.sv
module ppg_top #(
    parameter int NUM_PINS     = 4,
    parameter int STEP_W       = 3,
    parameter int IN_W         = 32,
    parameter int PER_W        = 30,
    parameter int MIN_NS       = 7,
    parameter int DEF_WIDTH_NS = 1000,
    localparam int PIN_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STEP_W-1:0]   tod_step,
    input  logic                tod_sec_wrap,
    input  logic                cfg_we,
    input  logic [PIN_W-1:0]    cfg_pin,
    input  logic                cfg_clock,
    input  logic                cfg_sync,
    input  logic [IN_W-1:0]     cfg_high,
    input  logic [IN_W-1:0]     cfg_low,
    output logic                cfg_reject,
    output logic [NUM_PINS-1:0] pin_out
);
    logic             chk_ok;
    logic [PER_W-1:0] chk_high;
    logic [PER_W-1:0] chk_low;

    ppg_cfg_check #(
        .IN_W(IN_W), .PER_W(PER_W), .MIN_NS(MIN_NS), .DEF_WIDTH_NS(DEF_WIDTH_NS)
    ) u_check (
        .run(cfg_clock), .sync(cfg_sync), .high_in(cfg_high), .low_in(cfg_low),
        .ok(chk_ok), .high_eff(chk_high), .low_eff(chk_low)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_reject <= 1'b0;
        end else begin
            cfg_reject <= cfg_we && !chk_ok;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic sel;
        assign sel = cfg_we && chk_ok && (cfg_pin == PIN_W'(p));

        ppg_pin_fsm #(.PER_W(PER_W), .STEP_W(STEP_W)) u_fsm (
            .clk(clk), .rst_n(rst_n),
            .load(sel), .load_run(cfg_clock), .load_sync(cfg_sync),
            .load_high(chk_high), .load_low(chk_low),
            .step(tod_step), .sec_wrap(tod_sec_wrap),
            .out(pin_out[p])
        );
    end
endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
    parameter int NUM_PINS = 4,
    parameter int PIN_W    = 2,
    parameter int STEP_W   = 3,
    parameter int IN_W     = 32,
    parameter int MIN_NS   = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic [STEP_W-1:0]   tod_step,
    input logic                tod_sec_wrap,
    input logic                cfg_we,
    input logic [PIN_W-1:0]    cfg_pin,
    input logic                cfg_clock,
    input logic                cfg_sync,
    input logic [IN_W-1:0]     cfg_high,
    input logic [IN_W-1:0]     cfg_low,
    input logic                cfg_reject,
    input logic [NUM_PINS-1:0] pin_out
);
    localparam logic [IN_W-1:0] MIN_V = IN_W'(MIN_NS);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0) && !cfg_reject);

    assert_stop_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_clock) |=> !pin_out[$past(cfg_pin)]);

    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_clock) |=> (cfg_reject || !pin_out[$past(cfg_pin)]));

    assert_short_low_rejected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_clock && !cfg_sync && (cfg_low < MIN_V)) |=> cfg_reject);

    assert_short_width_rejected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_clock && cfg_sync && (cfg_high != '0) && (cfg_high < MIN_V))
        |=> cfg_reject);

    assert_reject_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reject |-> $past(cfg_we));

    assert_frozen_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_step == '0 && !tod_sec_wrap && !cfg_we) |=> $stable(pin_out));
endmodule

bind ppg_top ppg_checker #(
    .NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .STEP_W(STEP_W), .IN_W(IN_W), .MIN_NS(MIN_NS)
) u_ppg_checker (
    .clk(clk), .rst_n(rst_n), .tod_step(tod_step), .tod_sec_wrap(tod_sec_wrap),
    .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_clock(cfg_clock), .cfg_sync(cfg_sync),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_reject(cfg_reject), .pin_out(pin_out)
);

// File: tb/test_ppg_top.sv
`timescale 1ns/1ps
module test_ppg_top;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    tod_step = '0;
    logic          tod_sec_wrap = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_pin = '0;
    logic          cfg_clock = 1'b0;
    logic          cfg_sync = 1'b0;
    logic [31:0]   cfg_high = '0;
    logic [31:0]   cfg_low = '0;
    logic          cfg_reject;
    logic [NP-1:0] pin_out;

    ppg_top i_ppg_top (
        .clk(clk), .rst_n(rst_n), .tod_step(tod_step), .tod_sec_wrap(tod_sec_wrap),
        .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_clock(cfg_clock), .cfg_sync(cfg_sync),
        .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_reject(cfg_reject), .pin_out(pin_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // scoreboard
    logic [NP:0] exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R1";
    int          step_v = 4;

    // reference model, time based
    int     m_mode[NP];   // 0 stop, 1 free, 2 sync armed, 3 sync running
    longint m_t[NP];
    longint m_lo[NP];
    longint m_hi[NP];

    localparam longint MAXV = 64'h3FFF_FFFF;

    function automatic bit in_rng(input longint v);
        return (v >= 7) && (v <= MAXV);
    endfunction

    task automatic tick(input bit we, input int pin, input bit run, input bit sy,
                        input longint hi, input longint lo, input bit wrap);
        logic [NP:0] e;
        bit rej;
        cfg_we       = we;
        cfg_pin      = 2'(pin);
        cfg_clock    = run;
        cfg_sync     = sy;
        cfg_high     = 32'(hi);
        cfg_low      = 32'(lo);
        tod_sec_wrap = wrap;
        tod_step     = 3'(step_v);
        rej = 0;
        for (int p = 0; p < NP; p++) begin
            bit acc;
            acc = 0;
            if (we && pin == p) begin
                bit valid;
                longint he;
                he = (hi == 0) ? (sy ? 1000 : lo) : hi;
                if (!run) valid = 1;
                else if (sy) valid = in_rng(he);
                else valid = in_rng(he) && in_rng(lo);
                if (!valid) rej = 1;
                else begin
                    acc = 1;
                    m_mode[p] = !run ? 0 : (sy ? 2 : 1);
                    m_t[p] = 0;
                    m_lo[p] = lo & MAXV;
                    m_hi[p] = he;
                end
            end
            if (!acc) begin
                case (m_mode[p])
                    1: m_t[p] = (m_t[p] + step_v) % (m_lo[p] + m_hi[p]);
                    2: if (wrap) begin m_mode[p] = 3; m_t[p] = 0; end
                    3: if (wrap) m_t[p] = 0;
                       else if (m_t[p] < 64'd1 << 40) m_t[p] = m_t[p] + step_v;
                    default: ;
                endcase
            end
            case (m_mode[p])
                1: e[p] = (m_t[p] >= m_lo[p]);
                3: e[p] = (m_t[p] >= m_lo[p]) && (m_t[p] < m_lo[p] + m_hi[p]);
                default: e[p] = 1'b0;
            endcase
        end
        e[NP] = rej;
        @(posedge clk);
        #1;
        exp_q.push_back(e);
        tag_q.push_back(cur_tag);
        cfg_we = 0;
        tod_sec_wrap = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0);
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [NP:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({cfg_reject, pin_out} !== e) begin
                bad++;
                $display("FAIL %s: actual reject/pins=%b expected=%b at %0t", t,
                         {cfg_reject, pin_out}, e, $time);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_mode[p] = 0; m_t[p] = 0; m_lo[p] = 0; m_hi[p] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;   // R1 during reset
        if (pin_out !== '0 || cfg_reject !== 1'b0) begin
            bad++;
            $display("FAIL R1: actual=%b expected=0", {cfg_reject, pin_out});
        end
        @(posedge clk); #1;
        rst_n = 1;
        cur_tag = "R1"; idle(3);

        // R3 free-running, two patterns
        cur_tag = "R3";
        tick(1, 0, 1, 0, 12, 20, 0);
        idle(20);
        tick(1, 1, 1, 0, 9, 7, 0);
        step_v = 7; idle(15);
        step_v = 4;
        // R5 default 50 %
        cur_tag = "R5";
        tick(1, 2, 1, 0, 0, 24, 0);
        idle(20);
        // R4 range checks, pin keeps waveform
        cur_tag = "R4";
        tick(1, 0, 1, 0, 12, 6, 0);
        idle(5);
        tick(1, 0, 1, 0, 64'h4000_0000, 20, 0);
        idle(5);
        tick(1, 0, 1, 0, 7, 64'h3FFF_FFFF, 0);
        idle(5);
        // R11 rejected and accepted writes elsewhere leave pin 2 running
        cur_tag = "R11";
        tick(1, 1, 1, 0, 5, 5, 0);
        idle(4);
        tick(1, 1, 1, 0, 7, 7, 0);
        idle(10);
        // R2 stop
        cur_tag = "R2";
        tick(1, 0, 0, 0, 0, 0, 0);
        tick(1, 1, 0, 1, 0, 0, 0);
        idle(6);
        // R12 frozen time base
        cur_tag = "R12";
        step_v = 0; idle(10); step_v = 4;
        // R6 and R8 synchronized mode
        cur_tag = "R6";
        tick(1, 1, 1, 1, 20, 8, 0);
        idle(5);
        tick(0, 0, 0, 0, 0, 0, 1);
        idle(15);
        cur_tag = "R8";
        tick(1, 3, 1, 1, 0, 16, 0);
        idle(4);
        tick(0, 0, 0, 0, 0, 0, 1);
        idle(260);
        // R7 width range
        cur_tag = "R7";
        tick(1, 3, 1, 1, 6, 0, 0);
        idle(3);
        tick(1, 3, 1, 1, 64'h3FFF_FFFF, 64'h0_FFFF_FFFF, 0);
        idle(3);
        // R9 rollover during pulse with zero offset
        cur_tag = "R9";
        tick(1, 1, 1, 1, 40, 0, 0);
        tick(0, 0, 0, 0, 0, 0, 1);
        for (int r = 0; r < 4; r++) begin
            idle(5);
            tick(0, 0, 0, 0, 0, 0, 1);
        end
        idle(15);
        // R9 rollover during pulse with nonzero offset
        tick(1, 1, 1, 1, 40, 8, 0);
        tick(0, 0, 0, 0, 0, 0, 1);
        idle(4);
        tick(0, 0, 0, 0, 0, 0, 1);
        idle(15);
        // R10 write on rollover edge
        cur_tag = "R10";
        tick(1, 2, 1, 1, 20, 8, 1);
        idle(8);
        tick(0, 0, 0, 0, 0, 0, 1);
        idle(12);
        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule